// File: doc/BRIEF.md
# Debug Exception Trigger Unit

This unit sits beside an instruction pipeline and decides when a debug exception must be raised. It watches three kinds of event. The first is a one-byte trap opcode reaching decode. The second is an instruction retiring while the trace flag in its flags word is set. The third is a fetch or completed data access that hits one of four programmable address watchpoints. In the cycle after the event, the unit asks for one exception and gives it a vector number. When several events arrive in the same cycle, it picks one of them by a fixed priority, but it records every hit in a sticky status register.

Software reaches the watchpoint addresses, the control word and the status word through a small register port. Writes take effect at the clock edge, and reads are combinational. After reset every register is zero, so no watchpoint can raise an exception until software enables it. The watchpoints sit in registers and compare against bus addresses, so they work on code that cannot be patched, such as code in read-only memory.

Top module: `dbg_trig_unit`

## Requirements
- R1: Decode of opcode 0xCC (decode_valid_i high) raises exc_req_o with exc_vec_o = 3 in the next cycle. Other opcodes raise nothing.
- R2: A retire with retire_flags_i[8] set raises exc_req_o with vector 1 in the next cycle and sets status bit 14. A retire with bit 8 clear raises nothing, whatever the other flag bits are.
- R3: The register map is as follows. Addresses 0 to 3 hold watchpoint addresses 0 to 3, address 4 holds the status word and address 5 holds the control word. Each written value reads back unchanged, apart from the unimplemented status bits, which read as zero.
- R4: After reset all registers read zero and exc_req_o is low. A fetch that hits the reset watchpoint addresses raises no exception.
- R5: An enabled execute watchpoint n is checked against fetch_addr_i when fetch_valid_i is high. On a hit, exc_req_o with vector 1 is raised in the cycle after the fetch strobe, and status bit n is set.
- R6: The control word holds a 2-bit type for watchpoint n at bits [17+4n:16+4n]. The codes are 00 execute, 01 data write, 11 data read or write, and 10 never matches. Data watchpoints are checked on completed accesses (data_valid_i, with data_we_i high for a write).
- R7: The control word holds a 2-bit length for watchpoint n at bits [19+4n:18+4n]. The codes are 00 for 1 byte, 01 for 2 bytes, and 10 or 11 for 4 bytes. The comparison ignores address bit 0 for 2 bytes and bits 1:0 for 4 bytes.
- R8: When several sources fire in one cycle, the vector follows this order: execute watchpoint (1), then trap opcode (3), then data watchpoint (1), then single-step (1). The status register still records every source that fired.
- R9: The enable for watchpoint n is control bit n. A disabled watchpoint whose address and type match still sets status bit n, but it raises no exception.
- R10: Status bits stay set until software writes the status word. A write replaces the word, and a hit in the same cycle as the write still sets its bit.
- R11: exc_req_o is a single-cycle pulse for each triggering cycle, and while it is high exc_vec_o is 1 or 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| decode_valid_i | input | 1 | Opcode valid at decode |
| decode_opcode_i | input | 8 | First opcode byte at decode |
| retire_i | input | 1 | Instruction retired |
| retire_flags_i | input | 32 | Flags word of the retiring instruction |
| fetch_valid_i | input | 1 | Instruction fetch strobe |
| fetch_addr_i | input | 32 | Fetch address |
| data_valid_i | input | 1 | Data access completed |
| data_we_i | input | 1 | Completed access was a write |
| data_addr_i | input | 32 | Data access address |
| exc_req_o | output | 1 | Exception request pulse |
| exc_vec_o | output | 8 | Exception vector number |

## Verification
The watchpoints are driven with exact address hits and with addresses one byte past the covered window. This separates the 1-, 2- and 4-byte masking, and a fetch or read to a write-only watchpoint checks that the type is decoded. The trap opcode and the trace flag are each tried both alone and next to near-miss inputs: a neighbouring opcode, and a flags word with every bit set except bit 8. Cycles where sources coincide show which vector wins while the status word holds every hit. A disabled watchpoint that matches, and a status write in the same cycle as a hit, show that recording is kept apart from raising the exception.

// File: rtl/dbg_trig_pkg.sv
package dbg_trig_pkg;
  typedef enum logic [1:0] {
    BT_EXEC = 2'b00,
    BT_WR   = 2'b01,
    BT_RSV  = 2'b10,
    BT_RW   = 2'b11
  } bp_type_e;

  localparam logic [7:0] OPC_TRAP  = 8'hCC;
  localparam logic [7:0] VEC_DEBUG = 8'd1;
  localparam logic [7:0] VEC_TRAP  = 8'd3;
endpackage

// File: rtl/dbg_bp_cmp.sv
module dbg_bp_cmp
  import dbg_trig_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic [AW-1:0] bp_addr_i,
  input  bp_type_e      type_i,
  input  logic [1:0]    len_i,
  input  logic          fetch_valid_i,
  input  logic [AW-1:0] fetch_addr_i,
  input  logic          data_valid_i,
  input  logic          data_we_i,
  input  logic [AW-1:0] data_addr_i,
  output logic          exec_hit_o,
  output logic          data_hit_o
);
  logic [AW-1:0] mask;
  logic          type_data;

  // R7 low bits covered by the length are don't-care
  always_comb begin
    mask = '1;
    unique case (len_i)
      2'b00:   mask = '1;
      2'b01:   mask[0] = 1'b0;
      default: mask[1:0] = 2'b00;
    endcase
  end

  always_comb begin
    unique case (type_i)
      BT_WR:   type_data = data_we_i;
      BT_RW:   type_data = 1'b1;
      default: type_data = 1'b0;
    endcase
  end

  assign exec_hit_o = fetch_valid_i && (type_i == BT_EXEC) &&
                      ((fetch_addr_i & mask) == (bp_addr_i & mask));
  assign data_hit_o = data_valid_i && type_data &&
                      ((data_addr_i & mask) == (bp_addr_i & mask));
endmodule

// File: rtl/dbg_prio.sv
module dbg_prio
  import dbg_trig_pkg::*;
(
  input  logic       exec_i,
  input  logic       trap_i,
  input  logic       data_i,
  input  logic       step_i,
  output logic       req_o,
  output logic [7:0] vec_o
);
  // R8 fixed order: exec > trap opcode > data > single-step
  always_comb begin
    req_o = 1'b1;
    vec_o = VEC_DEBUG;
    if (exec_i)      vec_o = VEC_DEBUG;
    else if (trap_i) vec_o = VEC_TRAP;
    else if (data_i) vec_o = VEC_DEBUG;
    else if (step_i) vec_o = VEC_DEBUG;
    else begin
      req_o = 1'b0;
      vec_o = '0;
    end
  end
endmodule

// File: rtl/dbg_trig_unit.sv
module dbg_trig_unit
  import dbg_trig_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned NUM_BP   = 4,
  parameter int unsigned FLAG_W   = 32,
  parameter int unsigned STEP_BIT = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              decode_valid_i,
  input  logic [7:0]        decode_opcode_i,
  input  logic              retire_i,
  input  logic [FLAG_W-1:0] retire_flags_i,
  input  logic              fetch_valid_i,
  input  logic [AW-1:0]     fetch_addr_i,
  input  logic              data_valid_i,
  input  logic              data_we_i,
  input  logic [AW-1:0]     data_addr_i,
  output logic              exc_req_o,
  output logic [7:0]        exc_vec_o
);
  localparam int unsigned STAT_STEP  = 14;
  localparam int unsigned FIELD_BASE = 16;
  localparam logic [2:0]  ADDR_STAT  = 3'd4;
  localparam logic [2:0]  ADDR_CTRL  = 3'd5;
  localparam logic [31:0] STAT_MASK  = (32'd1 << STAT_STEP) | ((32'd1 << NUM_BP) - 32'd1);

  logic [AW-1:0]     bp_addr_q [NUM_BP];
  logic [31:0]       ctrl_q, stat_q, stat_set;
  logic [NUM_BP-1:0] exec_hit, data_hit, bp_en;
  logic              exec_any, data_any, trap_op, step_ev, req_d;
  logic [7:0]        vec_d;

  assign bp_en = ctrl_q[NUM_BP-1:0];

  for (genvar g = 0; g < NUM_BP; g++) begin : g_bp
    dbg_bp_cmp #(.AW(AW)) u_cmp (
      .bp_addr_i    (bp_addr_q[g]),
      .type_i       (bp_type_e'(ctrl_q[FIELD_BASE+4*g +: 2])),
      .len_i        (ctrl_q[FIELD_BASE+4*g+2 +: 2]),
      .fetch_valid_i(fetch_valid_i),
      .fetch_addr_i (fetch_addr_i),
      .data_valid_i (data_valid_i),
      .data_we_i    (data_we_i),
      .data_addr_i  (data_addr_i),
      .exec_hit_o   (exec_hit[g]),
      .data_hit_o   (data_hit[g])
    );
  end

  assign exec_any = |(exec_hit & bp_en);
  assign data_any = |(data_hit & bp_en);
  assign trap_op  = decode_valid_i && (decode_opcode_i == OPC_TRAP);
  assign step_ev  = retire_i && retire_flags_i[STEP_BIT];

  dbg_prio u_prio (
    .exec_i(exec_any),
    .trap_i(trap_op),
    .data_i(data_any),
    .step_i(step_ev),
    .req_o (req_d),
    .vec_o (vec_d)
  );

  // R9 status records hits regardless of enable
  always_comb begin
    stat_set = '0;
    stat_set[NUM_BP-1:0] = exec_hit | data_hit;
    stat_set[STAT_STEP]  = step_ev;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_BP; i++) bp_addr_q[i] <= '0;
      ctrl_q    <= '0;
      stat_q    <= '0;
      exc_req_o <= 1'b0;
      exc_vec_o <= '0;
    end else begin
      exc_req_o <= req_d;
      exc_vec_o <= vec_d;
      for (int i = 0; i < NUM_BP; i++)
        if (reg_we_i && reg_addr_i == 3'(i)) bp_addr_q[i] <= reg_wdata_i[AW-1:0];
      if (reg_we_i && reg_addr_i == ADDR_CTRL) ctrl_q <= reg_wdata_i;
      // R10 write replaces, concurrent hit still sets
      if (reg_we_i && reg_addr_i == ADDR_STAT) stat_q <= (reg_wdata_i & STAT_MASK) | stat_set;
      else                                     stat_q <= stat_q | stat_set;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_STAT)      reg_rdata_o = stat_q;
    else if (reg_addr_i == ADDR_CTRL) reg_rdata_o = ctrl_q;
    else
      for (int i = 0; i < NUM_BP; i++)
        if (reg_addr_i == 3'(i)) reg_rdata_o = 32'(bp_addr_q[i]);
  end

  // R1
  trap_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_op && !exec_any) |=> (exc_req_o && exc_vec_o == VEC_TRAP));
  // R2
  step_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_ev |=> (exc_req_o && stat_q[STAT_STEP]));
  // R10
  stat_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q[0] && !(reg_we_i && reg_addr_i == ADDR_STAT)) |=> stat_q[0]);
  // R11
  vec_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_req_o |-> (exc_vec_o == VEC_DEBUG || exc_vec_o == VEC_TRAP));
  // R4
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_valid_i || data_valid_i || decode_valid_i || retire_i) |=> !exc_req_o);
endmodule

// File: tb/tb_dbg_trig_unit.sv
module tb_dbg_trig_unit;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        decode_valid_i = 1'b0;
  logic [7:0]  decode_opcode_i = '0;
  logic        retire_i = 1'b0;
  logic [31:0] retire_flags_i = '0;
  logic        fetch_valid_i = 1'b0;
  logic [31:0] fetch_addr_i = '0;
  logic        data_valid_i = 1'b0, data_we_i = 1'b0;
  logic [31:0] data_addr_i = '0;
  logic        exc_req_o;
  logic [7:0]  exc_vec_o;
  int errors = 0, checks = 0;

  always #2.5 clk_i = ~clk_i;

  dbg_trig_unit dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk_i);
    @(negedge clk_i);
    reg_we_i = 1'b0; decode_valid_i = 1'b0; retire_i = 1'b0;
    fetch_valid_i = 1'b0; data_valid_i = 1'b0; data_we_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    cyc();
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string tag);
    reg_addr_i = a;
    #1;
    chk(reg_rdata_o === e, tag, reg_rdata_o, e);
  endtask

  task automatic exc(input bit req, input logic [7:0] vec, input string tag);
    chk(exc_req_o === req && (!req || exc_vec_o === vec), tag,
        {23'd0, exc_req_o, exc_vec_o}, {23'd0, req, vec});
  endtask

  task automatic t_reset();
    exc(1'b0, 8'd0, "R4 reset req");
    rd(3'd4, 32'h0, "R4 reset status");
    rd(3'd5, 32'h0, "R4 reset ctrl");
    rd(3'd2, 32'h0, "R4 reset addr");
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h0;
    cyc();
    exc(1'b0, 8'd0, "R4 disabled after reset");
    rd(3'd4, 32'h0000000F, "R9 disabled hits recorded");
    wr(3'd4, 32'h0);
  endtask

  task automatic t_trap();
    decode_valid_i = 1'b1; decode_opcode_i = 8'hCC;
    cyc();
    exc(1'b1, 8'd3, "R1 trap opcode");
    cyc();
    exc(1'b0, 8'd0, "R11 single pulse");
    decode_valid_i = 1'b1; decode_opcode_i = 8'hCD;
    cyc();
    exc(1'b0, 8'd0, "R1 other opcode");
  endtask

  task automatic t_step();
    retire_i = 1'b1; retire_flags_i = 32'h0000_0100;
    cyc();
    exc(1'b1, 8'd1, "R2 step trap");
    rd(3'd4, 32'h0000_4000, "R2 step status");
    wr(3'd4, 32'h0);
    retire_i = 1'b1; retire_flags_i = 32'hFFFF_FEFF;
    cyc();
    exc(1'b0, 8'd0, "R2 flag clear");
    rd(3'd4, 32'h0, "R2 no status");
  endtask

  task automatic t_regs();
    wr(3'd0, 32'h1000); wr(3'd1, 32'h2000); wr(3'd2, 32'h3002); wr(3'd3, 32'h4000);
    wr(3'd5, 32'h07D0_0007);
    rd(3'd0, 32'h1000, "R3 addr0");
    rd(3'd3, 32'h4000, "R3 addr3");
    rd(3'd5, 32'h07D0_0007, "R3 ctrl");
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd4, 32'h0000_400F, "R3 status mask");
    wr(3'd4, 32'h0);
  endtask

  task automatic t_exec();
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h1000;
    cyc();
    exc(1'b1, 8'd1, "R5 exec hit");
    rd(3'd4, 32'h1, "R5 exec status");
    wr(3'd4, 32'h0);
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h1001;
    cyc();
    exc(1'b0, 8'd0, "R7 len1 miss");
    rd(3'd4, 32'h0, "R7 len1 status");
  endtask

  task automatic t_data();
    data_valid_i = 1'b1; data_we_i = 1'b1; data_addr_i = 32'h2003;
    cyc();
    exc(1'b1, 8'd1, "R6 write hit");
    rd(3'd4, 32'h2, "R6 write status");
    wr(3'd4, 32'h0);
    data_valid_i = 1'b1; data_we_i = 1'b0; data_addr_i = 32'h2000;
    cyc();
    exc(1'b0, 8'd0, "R6 read on write-only");
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h2000;
    cyc();
    exc(1'b0, 8'd0, "R6 fetch on data bp");
    rd(3'd4, 32'h0, "R6 no status");
    data_valid_i = 1'b1; data_we_i = 1'b0; data_addr_i = 32'h3003;
    cyc();
    exc(1'b1, 8'd1, "R7 len2 hit");
    rd(3'd4, 32'h4, "R7 len2 status");
    wr(3'd4, 32'h0);
    data_valid_i = 1'b1; data_we_i = 1'b1; data_addr_i = 32'h3004;
    cyc();
    exc(1'b0, 8'd0, "R7 len2 miss");
  endtask

  task automatic t_disabled();
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h4000;
    cyc();
    exc(1'b0, 8'd0, "R9 disabled no req");
    rd(3'd4, 32'h8, "R9 disabled status");
    wr(3'd4, 32'h0);
  endtask

  task automatic t_prio();
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h1000;
    decode_valid_i = 1'b1; decode_opcode_i = 8'hCC;
    cyc();
    exc(1'b1, 8'd1, "R8 exec over trap");
    wr(3'd4, 32'h0);
    decode_valid_i = 1'b1; decode_opcode_i = 8'hCC;
    data_valid_i = 1'b1; data_we_i = 1'b1; data_addr_i = 32'h2000;
    cyc();
    exc(1'b1, 8'd3, "R8 trap over data");
    rd(3'd4, 32'h2, "R8 data recorded");
    wr(3'd4, 32'h0);
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h1000;
    data_valid_i = 1'b1; data_we_i = 1'b1; data_addr_i = 32'h2000;
    retire_i = 1'b1; retire_flags_i = 32'h100;
    cyc();
    exc(1'b1, 8'd1, "R8 all sources");
    rd(3'd4, 32'h4003, "R8 all recorded");
  endtask

  task automatic t_sticky();
    cyc(); cyc(); cyc();
    rd(3'd4, 32'h4003, "R10 sticky");
    wr(3'd4, 32'h1);
    rd(3'd4, 32'h1, "R10 write replaces");
    reg_we_i = 1'b1; reg_addr_i = 3'd4; reg_wdata_i = 32'h0;
    fetch_valid_i = 1'b1; fetch_addr_i = 32'h1000;
    cyc();
    rd(3'd4, 32'h1, "R10 hit beats clear");
    wr(3'd4, 32'h0);
    rd(3'd4, 32'h0, "R10 cleared");
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_trap();
    t_step();
    t_regs();
    t_exec();
    t_data();
    t_disabled();
    t_prio();
    t_sticky();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule